// File: doc/BRIEF.md
# Flash Write-Status Read Generator

This block sits on the read path of a flash memory model. It decides which byte the data bus returns while an embedded program or erase is running. When no operation is in progress, every read returns the array byte unchanged. While an operation is running, a read returns an encoded status word instead. The top bit carries a data-polling flag. The bit below it flips on every read. The remaining low bits still follow the array.

The command decoder signals the write pulse that launches an operation with a one-cycle `op_start`. It supplies the operation kind, the byte being written and whether the target block is protected. The execution engine holds `op_busy` high for as long as the operation lasts, and that span includes any suspend or erase time-out window. A byte program aimed at a protected block does not need the engine. An internal timer keeps the status reporting alive for a fixed interval, and then the block drops back to idle. Reads are counted from the two active-low strobes, which are synchronised into the system clock.

Top module: `flash_status_gen`

## Requirements
- R1: While idle (no operation and no pending settle read), each read returns `array_data` unchanged on `rd_data`.
- R2: During a byte program (`op_kind` 2'b00), bit DW-1 of a read is the complement of bit DW-1 of the byte being written.
- R3: During a block erase (`op_kind` 2'b01) or chip erase (2'b10), bit DW-1 of a read is 0.
- R4: While an operation is active, bit DW-2 inverts on every read at any address. The first read after `op_start` returns 0 there.
- R5: The first read after an operation ends returns the true array bit DW-1, while bits DW-2..0 repeat the previous read word. Every later read returns the full array byte.
- R6: Status reporting starts with the first read after the `op_start` cycle. It holds for as long as `op_busy` stays high, however long that is (suspend or time-out window), and it ends once `op_busy` is low.
- R7: A byte program with `prot_hit` set reports status for ABORT_CYCLES clock cycles whatever `op_busy` does. Afterwards the block returns to idle and the array data is left as it was.
- R8: A read is counted once, on the transition into the state where both `ce_n` and `oe_n` are low. `rd_data` changes only when a read is counted and keeps its value while the strobes stay low.
- R9: While status is reported, bits DW-3..0 of a read follow `array_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_start | input | 1 | One-cycle pulse at the launching write pulse |
| op_kind | input | 2 | 00 byte program, 01 block erase, 10 chip erase |
| wr_byte | input | DW | Byte being programmed |
| prot_hit | input | 1 | Target block is protected |
| op_busy | input | 1 | Embedded operation (incl. suspend/time-out) running |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| array_data | input | DW | Byte read from the array at the current address |
| rd_data | output | DW | Byte returned for the latest counted read |

## Verification
The hardest case to reach is the settle read: the read that follows the end of an operation and mixes a true top bit with a stale lower part. It is only visible when the earlier read word and the array byte differ. The stimulus therefore draws a fresh random array byte for every read and ends each random operation with a settle read and then a plain read. The protected-program abort needs a run of reads that spans the whole timer interval. A directed case covers it with `op_busy` held low throughout, and a second directed case holds the strobes low while the array byte changes.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
   typedef enum logic [1:0] {
      OP_PROG       = 2'b00,
      OP_BLK_ERASE  = 2'b01,
      OP_CHIP_ERASE = 2'b10,
      OP_RSVD       = 2'b11
   } op_kind_e;
endpackage

// File: rtl/fsg_strobe_sync.sv
module fsg_strobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic oe_n,
   output logic rd_go
);
   logic [STAGES-1:0] ce_s;
   logic [STAGES-1:0] oe_s;
   logic              sel_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fsg_strobe_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ce_s[i] <= 1'b1;
               oe_s[i] <= 1'b1;
            end else if (i == 0) begin
               ce_s[i] <= ce_n;
               oe_s[i] <= oe_n;
            end else begin
               ce_s[i] <= ce_s[i-1];
               oe_s[i] <= oe_s[i-1];
            end
         end
      end
   endgenerate

   logic sel_now;
   assign sel_now = ~ce_s[STAGES-1] & ~oe_s[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= 1'b0;
      else        sel_q <= sel_now;
   end

   assign rd_go = sel_now & ~sel_q;
endmodule

// File: rtl/fsg_abort_timer.sv
module fsg_abort_timer #(
   parameter int CYCLES = 400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic running
);
   localparam int CW = $clog2(CYCLES + 1);

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("fsg_abort_timer: CYCLES must be positive");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= CW'(CYCLES);
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign running = (cnt_q != '0);
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
   import flash_status_pkg::*;
#(
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2,
   parameter int CLK_MHZ     = 200,
   parameter int ABORT_US    = 2,
   localparam int ABORT_CYCLES = CLK_MHZ * ABORT_US
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          op_start,
   input  logic [1:0]    op_kind,
   input  logic [DW-1:0] wr_byte,
   input  logic          prot_hit,
   input  logic          op_busy,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic [DW-1:0] array_data,
   output logic [DW-1:0] rd_data
);
   generate
      if (DW < 3) begin : g_bad_dw
         $error("flash_status_gen: DW must be at least 3");
      end
   endgenerate

   logic          rd_go;
   logic          abort_run;
   logic          abort_load;
   logic          act_q;
   logic          tog_q;
   logic          settle_q;
   op_kind_e      kind_q;
   logic [DW-1:0] byte_q;
   logic          poll_bit;
   logic [DW-1:0] status_word;

   fsg_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .ce_n  (ce_n),
      .oe_n  (oe_n),
      .rd_go (rd_go)
   );

   assign abort_load = op_start & prot_hit & (op_kind_e'(op_kind) == OP_PROG);

   fsg_abort_timer #(.CYCLES(ABORT_CYCLES)) u_abort (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (abort_load),
      .running (abort_run)
   );

   assign poll_bit    = (kind_q == OP_PROG) ? ~byte_q[DW-1] : 1'b0;
   assign status_word = {poll_bit, tog_q, array_data[DW-3:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q    <= 1'b0;
         tog_q    <= 1'b0;
         settle_q <= 1'b0;
         kind_q   <= OP_PROG;
         byte_q   <= '0;
         rd_data  <= '0;
      end else begin
         if (op_start) begin
            act_q    <= 1'b1;
            kind_q   <= op_kind_e'(op_kind);
            byte_q   <= wr_byte;
            tog_q    <= 1'b0;
            settle_q <= 1'b0;
         end else begin
            if (act_q && !op_busy && !abort_run) begin
               act_q    <= 1'b0;
               settle_q <= 1'b1;
            end
            if (rd_go) begin
               if (act_q) begin
                  rd_data <= status_word;
                  tog_q   <= ~tog_q;
               end else if (settle_q) begin
                  rd_data  <= {array_data[DW-1], rd_data[DW-2:0]};
                  settle_q <= 1'b0;
               end else begin
                  rd_data <= array_data;
               end
            end
         end
      end
   end
endmodule

// File: rtl/flash_status_gen_chk.sv
module flash_status_gen_chk
   import flash_status_pkg::*;
#(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rd_go,
   input logic          op_start,
   input logic          act_q,
   input logic          settle_q,
   input logic          tog_q,
   input op_kind_e      kind_q,
   input logic [DW-1:0] byte_q,
   input logic [DW-1:0] array_data,
   input logic [DW-1:0] rd_data
);
   // R1
   p_idle_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_go && !op_start && !act_q && !settle_q |=> rd_data == $past(array_data));

   // R2
   p_poll_prog_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_go && !op_start && act_q && kind_q == OP_PROG |=> rd_data[DW-1] == ~$past(byte_q[DW-1]));

   // R3
   p_poll_erase_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_go && !op_start && act_q && kind_q != OP_PROG |=> rd_data[DW-1] == 1'b0);

   // R4
   p_toggle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_go && !op_start |=> $stable(tog_q));

   // R5
   p_settle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_go && !op_start && !act_q && settle_q |=>
         rd_data[DW-1] == $past(array_data[DW-1]) && rd_data[DW-2:0] == $past(rd_data[DW-2:0]));

   // R8
   p_read_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_go |=> $stable(rd_data));

   // R9
   p_low_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_go && !op_start && act_q |=> rd_data[DW-3:0] == $past(array_data[DW-3:0]));
endmodule

bind flash_status_gen flash_status_gen_chk #(.DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_go      (rd_go),
   .op_start   (op_start),
   .act_q      (act_q),
   .settle_q   (settle_q),
   .tog_q      (tog_q),
   .kind_q     (kind_q),
   .byte_q     (byte_q),
   .array_data (array_data),
   .rd_data    (rd_data)
);

// File: tb/test_flash_status_gen.sv
module test_flash_status_gen;
   localparam int DW = 8;
   localparam int ABORT = 400;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          op_start = 1'b0;
   logic [1:0]    op_kind = 2'b00;
   logic [DW-1:0] wr_byte = '0;
   logic          prot_hit = 1'b0;
   logic          op_busy = 1'b0;
   logic          ce_n = 1'b1;
   logic          oe_n = 1'b1;
   logic [DW-1:0] array_data = '0;
   logic [DW-1:0] rd_data;

   int checks = 0;
   int errors = 0;
   logic [DW-1:0] last_word = '0;
   bit m_tog = 1'b0;
   int seed_dummy;

   always #2.5 clk = ~clk;

   flash_status_gen i_flash_status_gen (
      .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
      .wr_byte(wr_byte), .prot_hit(prot_hit), .op_busy(op_busy),
      .ce_n(ce_n), .oe_n(oe_n), .array_data(array_data), .rd_data(rd_data)
   );

   function automatic logic [DW-1:0] f_status(input logic [1:0] kind, input logic [DW-1:0] b,
                                              input bit tg, input logic [DW-1:0] arr);
      logic p;
      p = (kind == 2'b00) ? ~b[DW-1] : 1'b0;
      return {p, tg, arr[DW-3:0]};
   endfunction

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic do_read(input logic [DW-1:0] arr, output logic [DW-1:0] got);
      @(negedge clk);
      array_data = arr;
      ce_n = 1'b0;
      oe_n = 1'b0;
      repeat (8) @(negedge clk);
      got = rd_data;
      ce_n = 1'b1;
      oe_n = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic start_op(input logic [1:0] kind, input logic [DW-1:0] b, input bit prot, input bit busy);
      @(negedge clk);
      op_kind = kind; wr_byte = b; prot_hit = prot; op_busy = busy; op_start = 1'b1;
      @(negedge clk);
      op_start = 1'b0; prot_hit = 1'b0;
      m_tog = 1'b0;
   endtask

   task automatic status_read(input string req, input logic [1:0] kind, input logic [DW-1:0] b);
      logic [DW-1:0] arr, got, exp;
      arr = DW'($urandom);
      do_read(arr, got);
      exp = f_status(kind, b, m_tog, arr);
      check(req, got, exp);
      m_tog = ~m_tog;
      last_word = exp;
   endtask

   task automatic finish_op_reads(input string req);
      logic [DW-1:0] arr, got, exp;
      arr = DW'($urandom);
      do_read(arr, got);
      exp = {arr[DW-1], last_word[DW-2:0]};
      check({req, " settle read"}, got, exp);
      arr = DW'($urandom);
      do_read(arr, got);
      check({req, " after settle"}, got, arr);
      last_word = arr;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [DW-1:0] got, arr, held;
      seed_dummy = $urandom(32'd1357);
      repeat (4) @(negedge clk);
      check("R1 reset rd_data", rd_data, '0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1 idle passthrough
      for (int i = 0; i < 4; i++) begin
         arr = DW'($urandom);
         do_read(arr, got);
         check("R1 idle", got, arr);
         last_word = arr;
      end

      // R2 directed: program with top bit 1 and 0
      start_op(2'b00, 8'h80, 1'b0, 1'b1);
      status_read("R2 R4 prog top=1", 2'b00, 8'h80);
      status_read("R2 R4 prog second", 2'b00, 8'h80);
      @(negedge clk); op_busy = 1'b0;
      finish_op_reads("R5 prog");
      start_op(2'b00, 8'h3C, 1'b0, 1'b1);
      status_read("R2 prog top=0", 2'b00, 8'h3C);
      @(negedge clk); op_busy = 1'b0;
      finish_op_reads("R5 prog");

      // R3 chip erase and R6 long suspend window
      start_op(2'b10, 8'h00, 1'b0, 1'b1);
      status_read("R3 R6 chip erase", 2'b10, 8'h00);
      repeat (300) @(negedge clk);
      status_read("R6 suspend window", 2'b10, 8'h00);
      status_read("R3 R9 chip erase", 2'b10, 8'h00);
      @(negedge clk); op_busy = 1'b0;
      finish_op_reads("R5 R6 chip erase end");

      // R8 hold strobe low: one read only
      start_op(2'b01, 8'h00, 1'b0, 1'b1);
      @(negedge clk);
      array_data = 8'h15; ce_n = 1'b0; oe_n = 1'b0;
      repeat (8) @(negedge clk);
      held = rd_data;
      check("R8 R3 first of hold", held, f_status(2'b01, 8'h00, 1'b0, 8'h15));
      array_data = 8'h2A;
      repeat (20) @(negedge clk);
      check("R8 hold stable", rd_data, held);
      oe_n = 1'b1;
      repeat (6) @(negedge clk);
      oe_n = 1'b0;
      repeat (8) @(negedge clk);
      check("R8 R4 oe-only reread", rd_data, f_status(2'b01, 8'h00, 1'b1, 8'h2A));
      last_word = rd_data;
      ce_n = 1'b1; oe_n = 1'b1;
      repeat (6) @(negedge clk);
      op_busy = 1'b0;
      finish_op_reads("R5 block erase");

      // R7 protected program abort, busy held low
      start_op(2'b00, 8'h5A, 1'b1, 1'b0);
      for (int i = 0; i < 5; i++) status_read("R7 R2 protected toggle", 2'b00, 8'h5A);
      repeat (ABORT) @(negedge clk);
      finish_op_reads("R7 abort end");

      // random mix
      for (int t = 0; t < 40; t++) begin
         logic [1:0] k;
         logic [DW-1:0] b;
         int n;
         k = 2'($urandom_range(0, 2));
         b = DW'($urandom);
         n = $urandom_range(1, 6);
         start_op(k, b, 1'b0, 1'b1);
         for (int i = 0; i < n; i++) begin
            if (k == 2'b00) status_read("R2 R4 R9 random", k, b);
            else            status_read("R3 R4 R9 random", k, b);
         end
         @(negedge clk); op_busy = 1'b0;
         finish_op_reads("R5 R1 random");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule